// File: doc/BRIEF.md
# Serial Programming Write Completion Poller

This block drives a four-byte serial programming protocol toward a target device through its own SPI master, and decides when a flash or EEPROM write has finished. A request carries a write opcode, a 16-bit address and a data byte. The block shifts that frame out. If completion is wanted, it then reads the same location back repeatedly until the target returns the written value. For data values that the target cannot report reliably, it waits a fixed time instead. A page-commit request sends a commit frame and then completes against the most recently loaded byte.

The opcode used to read back is derived from the latched write opcode. A four-bit per-device quirk mask names the data values for which reading back is not trusted. The host sees a busy level, a one-cycle done strobe and a timeout flag. The timeout flag marks a poll that used up its retry budget without a match.

Top module: `isp_write_poller`

## Requirements
- R1: After reset, busy, done, timeout and spi_sck are all low.
- R2: A write request produces one frame of four bytes on spi_mosi: opcode, address bits 15:8, address bits 7:0, data. Each byte is sent MSB first in SPI mode 0: the clock idles low, spi_miso is sampled on the rising edge, and spi_mosi changes after the falling edge.
- R3: A read-back frame is (read opcode, latched address high, latched address low, 0x00). The read opcode is 0xA0 when the latched write opcode is 0xC0. Otherwise it is (opcode AND 0x08) OR 0x20. The byte received during the fourth exchange is the read result.
- R4: Read-back repeats until the result equals the latched data byte. Done then rises without timeout, so k mismatching reads followed by a match give k+1 read frames.
- R5: After the first read, at most MAX_RETRY further reads are made. If every one of them mismatches, done and timeout rise together after 1+MAX_RETRY read frames.
- R6: Quirk mask bit 0 covers value 0x00, bit 1 covers 0x7F, bit 2 covers 0x80 and bit 3 covers 0xFF. When the latched data equals a value whose bit is set, no read frame is sent. Done then follows the end of the last frame by WAIT_CYCLES = CLK_HZ*WAIT_US/1e6 cycles, plus at most 4 cycles of pipeline.
- R7: A page-commit request sends (0x4C, request address high, request address low, 0x00). It then completes through R3 to R6 against the latched opcode, address and data, and leaves those latches unchanged.
- R8: Every write request latches its opcode, address and data, including one that asks for no completion.
- R9: A write request with req_poll low ends with done, without timeout, right after its single frame.
- R10: req_valid is ignored while busy is high: it sends no frame and changes no latch.
- R11: Done is a one-cycle pulse that coincides with busy falling. Timeout is only ever high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only when not busy |
| req_page | input | 1 | 1 = page commit, 0 = write |
| req_poll | input | 1 | Write only: wait for completion after the frame |
| req_cmd | input | 8 | Write opcode |
| req_addr | input | 16 | Target address |
| req_data | input | 8 | Write data |
| quirk_mask | input | 4 | Values not to poll for, latched with the request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| timeout | output | 1 | Retry budget exhausted, valid with done |
| spi_sck | output | 1 | SPI clock to target |
| spi_mosi | output | 1 | SPI data to target |
| spi_miso | input | 1 | SPI data from target |

## Verification
The last permitted read and the retry-budget decision fall in the same cycle. That one frame's result decides both whether done rises and whether timeout rises with it. The bench holds the emulated target busy for exactly MAX_RETRY mismatching reads, and then for MAX_RETRY+1. The first case must give a clean done after the full read count. The second must give done with timeout and no extra frame. A request strobe raised during an active poll is also overlapped with the retry stream, and it is judged by the frame count seen at the SPI pins.

// File: rtl/isp_poll_pkg.sv
package isp_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMMIT,
    ST_READ,
    ST_WAIT
  } poll_state_e;

  localparam logic [7:0] OP_EE_WRITE    = 8'hC0;
  localparam logic [7:0] OP_EE_READ     = 8'hA0;
  localparam logic [7:0] OP_PAGE_COMMIT = 8'h4C;

  // Opcode used to read back the location a write opcode touched.
  function automatic logic [7:0] readback_op(input logic [7:0] wr_op);
    if (wr_op == OP_EE_WRITE) return OP_EE_READ;
    return (wr_op & 8'h08) | 8'h20;
  endfunction

  // True when the value cannot be trusted on read-back for this device.
  function automatic logic quirk_skip(input logic [3:0] mask, input logic [7:0] v);
    return (mask[0] && v == 8'h00) || (mask[1] && v == 8'h7F) ||
           (mask[2] && v == 8'h80) || (mask[3] && v == 8'hFF);
  endfunction

  // Byte i of a frame, byte 0 being the first on the wire.
  function automatic logic [7:0] frame_byte(input logic [31:0] f, input logic [1:0] i);
    return f[(31 - 8 * i) -: 8];
  endfunction

endpackage

// File: rtl/spi_byte_xchg.sv
module spi_byte_xchg #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active_q;
  logic          high_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic [7:0]    tx_sh_q;
  logic [7:0]    rx_sh_q;

  wire half_end = (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
      bit_q    <= '0;
      div_q    <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active_q) begin
        if (start) begin
          active_q <= 1'b1;
          tx_sh_q  <= tx_byte;
          mosi     <= tx_byte[7];
          div_q    <= '0;
          high_q   <= 1'b0;
          bit_q    <= '0;
        end
      end else if (!half_end) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!high_q) begin
          sck     <= 1'b1;
          high_q  <= 1'b1;
          rx_sh_q <= {rx_sh_q[6:0], miso};
        end else begin
          sck    <= 1'b0;
          high_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done     <= 1'b1;
          end else begin
            bit_q   <= bit_q + 3'd1;
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
            mosi    <= tx_sh_q[6];
          end
        end
      end
    end
  end

  assign rx_byte = rx_sh_q;
endmodule

// File: rtl/isp_frame_seq.sv
module isp_frame_seq
  import isp_poll_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] frame,
  output logic        done,
  output logic [7:0]  rx_last,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  logic [31:0] frame_q;
  logic [1:0]  idx_q;
  logic        x_done;
  logic [7:0]  x_rx;
  logic        x_start;
  logic [7:0]  x_tx;

  wire last_byte = (idx_q == 2'd3);

  always_comb begin
    x_start = start || (x_done && !last_byte);
    x_tx    = start ? frame[31:24] : frame_byte(frame_q, idx_q + 2'd1);
  end

  spi_byte_xchg #(.HALF_DIV(HALF_DIV)) u_xchg (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (x_start),
    .tx_byte (x_tx),
    .done    (x_done),
    .rx_byte (x_rx),
    .sck     (sck),
    .mosi    (mosi),
    .miso    (miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      done    <= 1'b0;
      rx_last <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        frame_q <= frame;
        idx_q   <= '0;
      end else if (x_done) begin
        if (last_byte) begin
          done    <= 1'b1;
          rx_last <= x_rx;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/isp_write_poller.sv
module isp_write_poller
  import isp_poll_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int WAIT_US      = 15_000,
  parameter int MAX_RETRY    = 256,
  parameter int SCK_HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_page,
  input  logic        req_poll,
  input  logic [7:0]  req_cmd,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_data,
  input  logic [3:0]  quirk_mask,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam longint WAIT_L      = (longint'(CLK_HZ) * longint'(WAIT_US)) / 64'd1000000;
  localparam int     WAIT_CYCLES = (WAIT_L < 1) ? 1 : int'(WAIT_L);
  localparam int     RW          = $clog2(MAX_RETRY + 1);

  poll_state_e state_q;
  logic [7:0]  last_cmd_q;
  logic [15:0] last_addr_q;
  logic [7:0]  last_val_q;
  logic [3:0]  mask_q;
  logic        poll_q;
  logic [RW-1:0] retry_q;
  logic        done_q;
  logic        tout_q;

  logic        fr_done;
  logic [7:0]  fr_rx;
  logic        tm_expire;
  logic        fs_start;
  logic [31:0] fs_frame;

  // Named events used by the FSM and by the checker.
  wire accept          = (state_q == ST_IDLE) && req_valid;
  wire in_read         = (state_q == ST_READ);
  wire out_frame_done  = fr_done && (state_q == ST_LOAD || state_q == ST_COMMIT);
  wire need_complete   = (state_q == ST_COMMIT) || poll_q;
  wire skip_poll       = quirk_skip(mask_q, last_val_q);
  wire start_poll      = out_frame_done && need_complete && !skip_poll;
  wire start_wait      = out_frame_done && need_complete && skip_poll;
  wire read_mismatch   = fr_done && in_read && (fr_rx != last_val_q);
  wire poll_match      = fr_done && in_read && (fr_rx == last_val_q);
  wire retry_exhausted = read_mismatch && (retry_q == RW'(MAX_RETRY));
  wire retry_again     = read_mismatch && (retry_q != RW'(MAX_RETRY));
  wire wait_over       = (state_q == ST_WAIT) && tm_expire;
  wire finish          = (out_frame_done && !need_complete) || poll_match ||
                         retry_exhausted || wait_over;

  wire [31:0] rd_frame = {readback_op(last_cmd_q), last_addr_q, 8'h00};

  always_comb begin
    fs_start = accept || start_poll || retry_again;
    if (accept && req_page)  fs_frame = {OP_PAGE_COMMIT, req_addr, 8'h00};
    else if (accept)         fs_frame = {req_cmd, req_addr, req_data};
    else                     fs_frame = rd_frame;
  end

  isp_frame_seq #(.HALF_DIV(SCK_HALF_DIV)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fs_start),
    .frame   (fs_frame),
    .done    (fr_done),
    .rx_last (fr_rx),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  wait_timer #(.CYCLES(WAIT_CYCLES)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_wait),
    .expire (tm_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      last_cmd_q  <= '0;
      last_addr_q <= '0;
      last_val_q  <= '0;
      mask_q      <= '0;
      poll_q      <= 1'b0;
      retry_q     <= '0;
      done_q      <= 1'b0;
      tout_q      <= 1'b0;
    end else begin
      done_q <= finish;
      tout_q <= retry_exhausted;
      if (accept) begin
        mask_q <= quirk_mask;
        if (req_page) begin
          state_q <= ST_COMMIT;
        end else begin
          state_q     <= ST_LOAD;
          poll_q      <= req_poll;
          last_cmd_q  <= req_cmd;
          last_addr_q <= req_addr;
          last_val_q  <= req_data;
        end
      end else if (finish) begin
        state_q <= ST_IDLE;
        poll_q  <= 1'b0;
      end else if (start_poll) begin
        state_q <= ST_READ;
        retry_q <= '0;
      end else if (start_wait) begin
        state_q <= ST_WAIT;
      end else if (retry_again) begin
        retry_q <= retry_q + 1'b1;
      end
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign timeout = tout_q;
endmodule

// File: rtl/isp_write_poller_chk.sv
module isp_write_poller_chk #(
  parameter int MAX_RETRY = 256,
  parameter int RW        = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          spi_sck,
  input logic          poll_match,
  input logic          retry_exhausted,
  input logic [RW-1:0] retry_q
);
  p_timeout_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  p_busy_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  p_match_clean_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_match |=> (done && !timeout));

  p_exhaust_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_exhausted |=> (done && timeout));

  p_retry_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RW'(MAX_RETRY));
endmodule

bind isp_write_poller isp_write_poller_chk #(
  .MAX_RETRY (MAX_RETRY),
  .RW        (RW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .busy            (busy),
  .done            (done),
  .timeout         (timeout),
  .spi_sck         (spi_sck),
  .poll_match      (poll_match),
  .retry_exhausted (retry_exhausted),
  .retry_q         (retry_q)
);

// File: tb/isp_write_poller_test.sv
module isp_write_poller_test;
  localparam int CLK_HZ    = 1_000_000;
  localparam int WAIT_US   = 40;
  localparam int WAIT_CYC  = 40;
  localparam int MAX_RETRY = 5;
  localparam int HALF      = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_page = 1'b0;
  logic        req_poll = 1'b0;
  logic [7:0]  req_cmd = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [3:0]  quirk_mask = '0;
  logic        busy, done, timeout, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  isp_write_poller #(
    .CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .MAX_RETRY(MAX_RETRY), .SCK_HALF_DIV(HALF)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
    .req_poll(req_poll), .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data),
    .quirk_mask(quirk_mask), .busy(busy), .done(done), .timeout(timeout),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Emulated target on the SPI pins, sampled away from the active edge.
  int          cyc = 0;
  int          last_fall = 0;
  int          done_cyc = 0;
  int          nfr = 0;
  int          bad_left = 0;
  logic [7:0]  tgt_val = '0;
  logic        prev_sck = 1'b0;
  int          bitcnt = 0;
  int          bytecnt = 0;
  logic [7:0]  sh = '0;
  logic [7:0]  fr [4];
  logic [7:0]  resp = '0;
  logic [31:0] lg [64];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      bitcnt = 0; bytecnt = 0; prev_sck = 1'b0;
    end else begin
      if (!prev_sck && spi_sck) begin
        sh = {sh[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt == 8) begin
          bitcnt = 0;
          fr[bytecnt] = sh;
          bytecnt++;
          if (bytecnt == 3) begin
            if (fr[0] == 8'h20 || fr[0] == 8'h28 || fr[0] == 8'hA0) begin
              if (bad_left > 0) begin
                resp = ~tgt_val;
                bad_left--;
              end else resp = tgt_val;
            end else resp = 8'h00;
          end
          if (bytecnt == 4) begin
            if (nfr < 64) lg[nfr] = {fr[0], fr[1], fr[2], fr[3]};
            nfr++;
            bytecnt = 0;
          end
        end
      end
      if (prev_sck && !spi_sck) begin
        last_fall = cyc;
        spi_miso = (bytecnt == 3) ? resp[7 - bitcnt] : 1'b0;
      end
      prev_sck = spi_sck;
      if (done) done_cyc = cyc;
    end
  end

  logic got_tout;

  task automatic issue(input logic page, input logic poll, input logic [7:0] cmd,
                       input logic [15:0] addr, input logic [7:0] data,
                       input logic [3:0] mask);
    @(negedge clk);
    nfr = 0;
    req_page = page; req_poll = poll; req_cmd = cmd; req_addr = addr;
    req_data = data; quirk_mask = mask; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(string rq);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 20000);
    got_tout = timeout;
    @(negedge clk);
    check({rq, " R11 done pulse width"}, {31'd0, done}, 32'd0);
  endtask

  function automatic logic [7:0] exp_rdop(input logic [7:0] c);
    if (c == 8'hC0) return 8'hA0;
    return c[3] ? 8'h28 : 8'h20;
  endfunction

  function automatic logic exp_skip(input logic [3:0] m, input logic [7:0] v);
    case (v)
      8'h00:   return m[0];
      8'h7F:   return m[1];
      8'h80:   return m[2];
      8'hFF:   return m[3];
      default: return 1'b0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] vals [5];
    vals[0] = 8'h00; vals[1] = 8'h7F; vals[2] = 8'h80; vals[3] = 8'hFF; vals[4] = 8'h5A;

    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 timeout", {31'd0, timeout}, 32'd0);
    check("R1 sck", {31'd0, spi_sck}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: every write opcode, frame order and derived read opcode
    for (int c = 0; c < 256; c++) begin
      logic [15:0] a;
      a = 16'(c * 257) ^ 16'hA5C3;
      tgt_val = 8'h5A; bad_left = 0;
      issue(1'b0, 1'b1, 8'(c), a, 8'h5A, 4'h0);
      wait_done("R3");
      check("R2 frame count", 32'(nfr), 32'd2);
      check("R2 write frame", lg[0], {8'(c), a, 8'h5A});
      check("R3 read frame", lg[1], {exp_rdop(8'(c)), a, 8'h00});
      check("R4 no timeout", {31'd0, got_tout}, 32'd0);
    end

    // R4: k busy reads then a match, up to the last allowed attempt
    for (int k = 0; k <= MAX_RETRY; k++) begin
      tgt_val = 8'h33; bad_left = k;
      issue(1'b0, 1'b1, 8'hC0, 16'h0456, 8'h33, 4'hF);
      wait_done("R4");
      check("R4 frame count", 32'(nfr), 32'(k + 2));
      check("R4 timeout low", {31'd0, got_tout}, 32'd0);
      check("R4 last read frame", lg[k + 1], {8'hA0, 16'h0456, 8'h00});
    end

    // R5: budget exhausted by one mismatch more, and by many
    for (int j = 0; j < 2; j++) begin
      tgt_val = 8'h21; bad_left = (j == 0) ? MAX_RETRY + 1 : 40;
      issue(1'b0, 1'b1, 8'h40, 16'h0F0F, 8'h21, 4'h0);
      wait_done("R5");
      check("R5 frame count", 32'(nfr), 32'(MAX_RETRY + 2));
      check("R5 timeout high", {31'd0, got_tout}, 32'd1);
    end

    // R6: quirk mask sweep against the special values
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 5; v++) begin
        logic sk;
        sk = exp_skip(4'(m), vals[v]);
        tgt_val = vals[v]; bad_left = 0;
        issue(1'b0, 1'b1, 8'h40, 16'h0100, vals[v], 4'(m));
        wait_done("R6");
        check("R6 frame count", 32'(nfr), sk ? 32'd1 : 32'd2);
        check("R6 timeout low", {31'd0, got_tout}, 32'd0);
        if (sk) begin
          check("R6 wait not early", {31'd0, (done_cyc - last_fall) >= WAIT_CYC}, 32'd1);
          check("R6 wait not late", {31'd0, (done_cyc - last_fall) <= WAIT_CYC + 4}, 32'd1);
        end
      end
    end

    // R9/R8: load without completion, then page commits use the latches (R7)
    tgt_val = 8'h3C; bad_left = 0;
    issue(1'b0, 1'b0, 8'h48, 16'h1234, 8'h3C, 4'h0);
    wait_done("R9");
    check("R9 single frame", 32'(nfr), 32'd1);
    check("R9 timeout low", {31'd0, got_tout}, 32'd0);
    check("R8 load frame", lg[0], {8'h48, 16'h1234, 8'h3C});

    bad_left = 2;
    issue(1'b1, 1'b0, 8'h00, 16'h0100, 8'h00, 4'h0);
    wait_done("R7");
    check("R7 frame count", 32'(nfr), 32'd4);
    check("R7 commit frame", lg[0], {8'h4C, 16'h0100, 8'h00});
    check("R8 poll uses latched load", lg[3], {8'h28, 16'h1234, 8'h00});
    check("R7 timeout low", {31'd0, got_tout}, 32'd0);

    bad_left = 0;
    issue(1'b1, 1'b0, 8'h00, 16'h0200, 8'h00, 4'h0);
    wait_done("R7");
    check("R7 latches unchanged", lg[1], {8'h28, 16'h1234, 8'h00});

    tgt_val = 8'hFF;
    issue(1'b0, 1'b0, 8'hC0, 16'h0042, 8'hFF, 4'h0);
    wait_done("R8");
    issue(1'b1, 1'b0, 8'h00, 16'h0300, 8'h00, 4'h8);
    wait_done("R7");
    check("R7 quirk commit one frame", 32'(nfr), 32'd1);
    check("R7 quirk wait", {31'd0, (done_cyc - last_fall) >= WAIT_CYC}, 32'd1);

    // R10: a request during an active poll is ignored
    tgt_val = 8'h11; bad_left = 3;
    issue(1'b0, 1'b1, 8'hC0, 16'h0777, 8'h11, 4'h0);
    repeat (30) @(negedge clk);
    req_page = 1'b1; req_addr = 16'h0999; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R10");
    check("R10 frame count", 32'(nfr), 32'd5);
    check("R10 write frame", lg[0], {8'hC0, 16'h0777, 8'h11});
    check("R10 read frame", lg[4], {8'hA0, 16'h0777, 8'h00});
    repeat (300) @(negedge clk);
    check("R10 no late frame", 32'(nfr), 32'd5);
    check("R10 idle after", {31'd0, busy}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule